// File: doc/BRIEF.md
# ADC Conversion Launch Sequencer

This block sits between the on-chip trigger sources and an analog-to-digital converter macro and decides exactly when each conversion begins sampling. It holds a 32-bit control word with a converter clock divider, a clock source select, a power-saving enable and a self-clearing calibration request. From these it derives a converter clock enable, drives the analog power enable, and emits a one-cycle sample start pulse. The pulse falls a fixed, predictable number of system clocks after the trigger that caused it.

With the synchronous clock source, the divider phase restarts on each accepted trigger, so launch latency depends only on the divide value. A bypass input shortens this to a fixed two-clock delay. With the external clock source, the divider is ignored and launch follows the next external tick. In power-saving mode the analog core is unpowered while idle. Each trigger then powers it up and waits a resolution-dependent warm-up before sampling. Triggers that arrive while busy are merged into one pending request, and a pending request keeps the core powered for the next conversion. While calibration runs, the control word is locked and triggers are held until it ends.

Top module: `adc_launch_seq`

## Requirements
- R1: After reset the control word reads 0. Its fields are: divide value in bits 7:0, clock source select in bit 8 (0 = system clock divided, 1 = external tick), power-saving enable in bit 10, and calibration request in bit 30. All other bits read 0 whatever is written.
- R2: With the divided system clock, no bypass and power saving off, `sample_start` is seen divide+2 clocks after the clock edge that samples `trig`, counting that edge as the first.
- R3: With the divided system clock and `bypass` high, the launch delay of R2 is 2 clocks whatever the divide value.
- R4: With the external tick source, the divide value is ignored. After a trigger, `sample_start` appears only on the clock after the first sampled `async_tick`.
- R5: With power saving on, `analog_pwr_en` is low while idle. It is high from the clock after an accepted trigger. With power saving off, it equals `adc_enable`.
- R6: With power saving on, the first launch is delayed by N*(divide+1)+1 clocks. N is 15 converter ticks, or 30 when `res_hi` is high. `bypass` has no effect on this warm-up.
- R7: When a conversion ends in power-saving mode, the core powers down unless a trigger is pending. A pending trigger relaunches at once, with no warm-up and with power held on.
- R8: While `adc_enable` is low, triggers are dropped: no power-up, no busy, and nothing launches later when the enable returns.
- R9: Writing 1 to bit 30 starts calibration. The other fields of that same write take effect. Bit 30 clears by itself after 64 converter ticks.
- R10: While calibration runs, every write to the control word is ignored.
- R11: A trigger that arrives during calibration is held and launched after calibration ends.
- R12: `busy` is high from the clock after an accepted trigger until the clock after `conv_done`, unless a pending trigger relaunches.
- R13: `sample_start` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read value |
| adc_enable | input | 1 | Global converter enable |
| res_hi | input | 1 | High-resolution select (longer warm-up) |
| bypass | input | 1 | Fixed two-clock launch in synchronous mode |
| trig | input | 1 | Conversion trigger, one clock wide |
| async_tick | input | 1 | Converter tick from the external clock source |
| conv_done | input | 1 | Conversion finished, from the analog macro |
| conv_clk_en | output | 1 | Converter clock enable while active or calibrating |
| analog_pwr_en | output | 1 | Analog core power enable |
| sample_start | output | 1 | Start-of-sampling pulse to the analog macro |
| busy | output | 1 | Conversion in progress |

## Verification
Launch latency is measured over random divide values, resolutions, bypass settings and power modes. This separates the three latency formulas, and a phase error in the divider restart shows up as an off-by-one. Directed cases cover the following:
- A trigger arriving mid-conversion, which tells a pending relaunch apart from a fresh warm-up.
- A trigger with the enable low, which shows that dropping differs from deferring.
- Writes and triggers during calibration, which separate the write lock from the trigger hold.
- The external tick source with a non-zero divider, which shows whether the divider is truly ignored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WARM   = 2'd1,
    ST_LAUNCH = 2'd2,
    ST_CONV   = 2'd3
  } seq_state_e;

  localparam int unsigned CTRL_W   = 32;
  localparam int unsigned SRC_BIT  = 8;
  localparam int unsigned LP_BIT   = 10;
  localparam int unsigned CAL_BIT  = 30;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             async_sel,
  input  logic [DIV_W-1:0] div,
  input  logic             restart,
  input  logic             async_tick,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             at_top;

  always_comb begin
    at_top = (cnt_q == div);
    if (restart || at_top) cnt_d = '0;
    else                   cnt_d = cnt_q + DIV_W'(1);
    tick = async_sel ? async_tick : at_top;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/adc_ctrl_regs.sv
module adc_ctrl_regs
  import adc_seq_pkg::*;
#(
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned CAL_TICKS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              tick,
  output logic [DIV_W-1:0]  div,
  output logic              async_sel,
  output logic              lp_en,
  output logic              cal_busy,
  output logic [CTRL_W-1:0] rdata
);
  localparam int unsigned CW = (CAL_TICKS > 2) ? $clog2(CAL_TICKS) : 1;

  logic [DIV_W-1:0] div_q, div_d;
  logic             src_q, src_d, lp_q, lp_d, cal_q, cal_d;
  logic [CW-1:0]    ccnt_q, ccnt_d;
  logic             wr_ok, cal_end;
  logic             unused_wbits;

  assign unused_wbits = ^{wdata[CTRL_W-1:CAL_BIT+1], wdata[CAL_BIT-1:LP_BIT+1],
                          wdata[LP_BIT-1:SRC_BIT+1], wdata[SRC_BIT-1:DIV_W]};

  always_comb begin
    wr_ok   = wr_en && !cal_q;
    cal_end = cal_q && tick && (ccnt_q == CW'(CAL_TICKS - 1));
    div_d   = div_q;
    src_d   = src_q;
    lp_d    = lp_q;
    cal_d   = cal_q;
    ccnt_d  = ccnt_q;
    if (wr_ok) begin
      div_d  = wdata[DIV_W-1:0];
      src_d  = wdata[SRC_BIT];
      lp_d   = wdata[LP_BIT];
      cal_d  = wdata[CAL_BIT];
      ccnt_d = '0;
    end else if (cal_q && tick) begin
      ccnt_d = ccnt_q + CW'(1);
      if (cal_end) cal_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      src_q  <= 1'b0;
      lp_q   <= 1'b0;
      cal_q  <= 1'b0;
      ccnt_q <= '0;
    end else begin
      div_q  <= div_d;
      src_q  <= src_d;
      lp_q   <= lp_d;
      cal_q  <= cal_d;
      ccnt_q <= ccnt_d;
    end
  end

  always_comb begin
    rdata                = '0;
    rdata[DIV_W-1:0]     = div_q;
    rdata[SRC_BIT]       = src_q;
    rdata[LP_BIT]        = lp_q;
    rdata[CAL_BIT]       = cal_q;
  end

  assign div       = div_q;
  assign async_sel = src_q;
  assign lp_en     = lp_q;
  assign cal_busy  = cal_q;

  AST_CAL_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_q && wr_en) |=> ($stable(div_q) && $stable(src_q) && $stable(lp_q))); // R10
  AST_CAL_CLEAR_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cal_q) |-> $past(tick)); // R9
endmodule

// File: rtl/adc_launch_fsm.sv
module adc_launch_fsm
  import adc_seq_pkg::*;
#(
  parameter int unsigned STARTUP_TICKS    = 15,
  parameter int unsigned STARTUP_TICKS_HI = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic adc_enable,
  input  logic bypass,
  input  logic res_hi,
  input  logic async_sel,
  input  logic lp_en,
  input  logic cal_busy,
  input  logic tick,
  input  logic conv_done,
  output logic restart,
  output logic sample_start,
  output logic busy,
  output logic pwr_en
);
  localparam int unsigned SW = $clog2(STARTUP_TICKS_HI + 1);

  seq_state_e    st_q, st_d;
  logic [SW-1:0] wcnt_q, wcnt_d, lim;
  logic          pend_q, pend_d, samp_q;
  logic          start_req, can_go, accept, relaunch, fire;

  always_comb begin
    start_req = trig || pend_q;
    can_go    = adc_enable && !cal_busy;
    lim       = res_hi ? SW'(STARTUP_TICKS_HI) : SW'(STARTUP_TICKS);
    st_d      = st_q;
    wcnt_d    = wcnt_q;
    accept    = 1'b0;
    relaunch  = 1'b0;
    fire      = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start_req && can_go) begin
        accept = 1'b1;
        wcnt_d = '0;
        st_d   = lp_en ? ST_WARM : ST_LAUNCH;
      end
      ST_WARM: if (tick) begin
        if (wcnt_q == lim - SW'(1)) begin
          fire = 1'b1;
          st_d = ST_CONV;
        end else begin
          wcnt_d = wcnt_q + SW'(1);
        end
      end
      ST_LAUNCH: if ((!async_sel && bypass) || tick) begin
        fire = 1'b1;
        st_d = ST_CONV;
      end
      ST_CONV: if (conv_done) begin
        if (start_req && can_go) begin
          relaunch = 1'b1;
          st_d     = ST_LAUNCH;
        end else begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    restart = accept || relaunch;
    pend_d  = restart ? 1'b0 : (pend_q || (trig && adc_enable));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wcnt_q <= '0;
      pend_q <= 1'b0;
      samp_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      pend_q <= pend_d;
      samp_q <= fire;
    end
  end

  assign sample_start = samp_q;
  assign busy         = (st_q != ST_IDLE);
  assign pwr_en       = adc_enable && (!lp_en || busy || cal_busy);

  AST_SAMPLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_start |=> !sample_start); // R13
  AST_SAMPLE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sample_start |-> busy); // R12
  AST_LAUNCH_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(adc_enable)); // R8
  AST_LAUNCH_AFTER_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(cal_busy)); // R11
endmodule

// File: rtl/adc_launch_seq.sv
module adc_launch_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned DIV_W            = 8,
  parameter int unsigned CAL_TICKS        = 64,
  parameter int unsigned STARTUP_TICKS    = 15,
  parameter int unsigned STARTUP_TICKS_HI = 30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        adc_enable,
  input  logic        res_hi,
  input  logic        bypass,
  input  logic        trig,
  input  logic        async_tick,
  input  logic        conv_done,
  output logic        conv_clk_en,
  output logic        analog_pwr_en,
  output logic        sample_start,
  output logic        busy
);
  logic             rst_meta_q, rst_sync_q;
  logic [DIV_W-1:0] div;
  logic             async_sel, lp_en, cal_busy, tick, restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  adc_ctrl_regs #(.DIV_W(DIV_W), .CAL_TICKS(CAL_TICKS)) regs_i (
    .clk(clk), .rst_n(rst_sync_q), .wr_en(reg_wr_en), .wdata(reg_wdata),
    .tick(tick), .div(div), .async_sel(async_sel), .lp_en(lp_en),
    .cal_busy(cal_busy), .rdata(reg_rdata)
  );

  adc_tick_gen #(.DIV_W(DIV_W)) tick_i (
    .clk(clk), .rst_n(rst_sync_q), .async_sel(async_sel), .div(div),
    .restart(restart), .async_tick(async_tick), .tick(tick)
  );

  adc_launch_fsm #(.STARTUP_TICKS(STARTUP_TICKS), .STARTUP_TICKS_HI(STARTUP_TICKS_HI)) fsm_i (
    .clk(clk), .rst_n(rst_sync_q), .trig(trig), .adc_enable(adc_enable),
    .bypass(bypass), .res_hi(res_hi), .async_sel(async_sel), .lp_en(lp_en),
    .cal_busy(cal_busy), .tick(tick), .conv_done(conv_done), .restart(restart),
    .sample_start(sample_start), .busy(busy), .pwr_en(analog_pwr_en)
  );

  assign conv_clk_en = tick && (busy || cal_busy);
endmodule

// File: tb/adc_launch_seq_tb_top.sv
module adc_launch_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en, adc_enable, res_hi, bypass, trig, async_tick, conv_done;
  logic [31:0] reg_wdata, reg_rdata;
  logic        conv_clk_en, analog_pwr_en, sample_start, busy;
  int          n_chk = 0;
  int          n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_launch_seq dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .adc_enable(adc_enable), .res_hi(res_hi),
    .bypass(bypass), .trig(trig), .async_tick(async_tick), .conv_done(conv_done),
    .conv_clk_en(conv_clk_en), .analog_pwr_en(analog_pwr_en),
    .sample_start(sample_start), .busy(busy)
  );

  function automatic int exp_lat(int dv, bit lp, bit rh, bit byp);
    if (lp)  return (rh ? 30 : 15) * (dv + 1) + 1;
    if (byp) return 2;
    return dv + 2;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic wr(logic [31:0] v);
    @(negedge clk); reg_wr_en = 1'b1; reg_wdata = v;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic launch(output int lat);
    lat = 0;
    @(negedge clk); trig = 1'b1;
    for (int n = 1; n <= 400; n++) begin
      @(negedge clk); trig = 1'b0;
      if (sample_start) begin lat = n; break; end
    end
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
  endtask

  task automatic finish_conv();
    @(negedge clk); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int lat, n;
    void'($urandom(32'd2718));
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wdata = '0; adc_enable = 1'b0;
    res_hi = 1'b0; bypass = 1'b0; trig = 1'b0; async_tick = 1'b0; conv_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(reg_rdata == 32'h0, "R1 reset word", reg_rdata, 0);
    chk(!busy && !sample_start, "R12 reset busy", busy, 0);
    chk(!analog_pwr_en, "R5 power off when disabled", analog_pwr_en, 0);
    adc_enable = 1'b1;
    @(negedge clk);
    chk(analog_pwr_en, "R5 power follows enable", analog_pwr_en, 1);

    // R1 field layout, reserved bits read 0
    wr(32'hBFFF_FFFF);
    chk(reg_rdata == 32'h0000_05FF, "R1 layout", reg_rdata, 32'h5FF);
    wr(32'h0);
    chk(reg_rdata == 32'h0, "R1 clear", reg_rdata, 0);

    // R3 bypass, R2 divided latency
    bypass = 1'b1; wr(32'd5);
    launch(lat); chk(lat == 2, "R3 bypass latency", lat, 2);
    chk(busy, "R12 busy during conversion", busy, 1);
    finish_conv(); chk(!busy, "R12 busy drops", busy, 0);
    bypass = 1'b0;
    launch(lat); chk(lat == 7, "R2 div5 latency", lat, 7);
    finish_conv();

    // R4 external tick source ignores divider
    wr(32'h0000_0105);
    pulse_trig();
    n = 0;
    repeat (10) begin @(negedge clk); if (sample_start) n++; end
    chk(n == 0, "R4 no launch before tick", n, 0);
    async_tick = 1'b1;
    @(negedge clk);
    chk(sample_start, "R4 launch after tick", sample_start, 1);
    async_tick = 1'b0;
    finish_conv();

    // R5 R6 power saving warm-up
    wr(32'h0000_0400);
    @(negedge clk);
    chk(!analog_pwr_en, "R5 idle power off", analog_pwr_en, 0);
    launch(lat); chk(lat == 16, "R6 warm-up 15", lat, 16);
    chk(analog_pwr_en, "R5 power on in conversion", analog_pwr_en, 1);
    finish_conv(); chk(!analog_pwr_en, "R7 power off after done", analog_pwr_en, 0);
    res_hi = 1'b1; bypass = 1'b1;
    launch(lat); chk(lat == 31, "R6 warm-up 30 ignores bypass", lat, 31);
    finish_conv();
    res_hi = 1'b0; bypass = 1'b0;
    wr(32'h0000_0402);
    launch(lat); chk(lat == 46, "R6 warm-up div2", lat, 46);
    finish_conv();

    // R7 pending relaunch keeps power, no warm-up
    wr(32'h0000_0400);
    launch(lat); chk(lat == 16, "R6 warm-up before pending", lat, 16);
    pulse_trig();
    finish_conv();
    chk(busy && analog_pwr_en, "R7 power held for pending", analog_pwr_en, 1);
    @(negedge clk);
    chk(sample_start, "R7 relaunch without warm-up", sample_start, 1);
    finish_conv();
    chk(!analog_pwr_en && !busy, "R7 power off when nothing pending", analog_pwr_en, 0);

    // R8 disabled triggers are dropped
    adc_enable = 1'b0;
    pulse_trig();
    repeat (4) @(negedge clk);
    chk(!busy && !analog_pwr_en, "R8 no launch while disabled", busy, 0);
    adc_enable = 1'b1;
    repeat (6) @(negedge clk);
    chk(!busy, "R8 trigger not remembered", busy, 0);

    // R9 calibration length and same-write fields
    wr(32'h4000_0400);
    chk(reg_rdata == 32'h4000_0400, "R9 fields with cal write", reg_rdata, 32'h4000_0400);
    n = 0;
    while (reg_rdata[30] && n < 500) begin n++; @(negedge clk); end
    chk(n == 64, "R9 cal length", n, 64);
    chk(reg_rdata == 32'h0000_0400, "R9 cal self clear", reg_rdata, 32'h400);

    // R10 R11 lock and trigger hold
    bypass = 1'b1;
    wr(32'h4000_0000);
    wr(32'h0000_0003);
    chk(reg_rdata == 32'h4000_0000, "R10 write ignored during cal", reg_rdata, 32'h4000_0000);
    pulse_trig();
    repeat (4) @(negedge clk);
    chk(!busy, "R11 trigger held during cal", busy, 0);
    n = 0;
    while (reg_rdata[30] && n < 500) begin n++; @(negedge clk); end
    repeat (3) @(negedge clk);
    chk(busy, "R11 held trigger launched", busy, 1);
    finish_conv();
    bypass = 1'b0;

    // random sweep of latency formulas
    for (int i = 0; i < 24; i++) begin
      int  dv;
      bit  lp, rh, byp;
      dv  = int'($urandom % 6);
      lp  = 1'($urandom % 2);
      rh  = 1'($urandom % 2);
      byp = 1'($urandom % 2);
      res_hi = rh; bypass = byp;
      wr((32'(lp) << 10) | 32'(dv));
      launch(lat);
      chk(lat == exp_lat(dv, lp, rh, byp), lp ? "R6 random" : (byp ? "R3 random" : "R2 random"),
          lat, exp_lat(dv, lp, rh, byp));
      repeat ($urandom % 4) @(negedge clk);
      finish_conv();
      chk(!busy && (analog_pwr_en == !lp), "R5 random idle power", analog_pwr_en, !lp);
    end

    finish_run();
  end
endmodule